// File: doc/BRIEF.md
# Temperature Result Scratchpad with Threshold Alarm

This block keeps the outcome of the most recent temperature conversion together with two signed trigger bytes and a resolution setting. A conversion is started by a one-cycle strobe. On that strobe the block captures a 12-bit two's-complement sample from an abstract converter. The sample is in units of 1/16 degree. The block then counts out a latency that depends on the chosen resolution. When the count finishes, it stores the sample as a 16-bit sign-extended word with the insignificant fraction bits cleared. At the same moment it re-evaluates a sticky alarm flag against the trigger bytes.

Software-style access goes through a byte-wide register port. The port is always ready. A read returns its data one cycle after it is accepted, marked by a response valid. The trigger bytes are signed whole degrees. They are compared with the integer part of the stored result, bits 11 to 4. The conversion latency is `STEP_CYCLES` clock cycles per unit, and a 9-bit conversion takes one unit. Each further resolution bit doubles the latency.

Top module: `temp_scratchpad`

## Requirements
- R1: After reset the result word is 0x0000, the high trigger is 0x7F, the low trigger is 0x80, the config byte reads 0x7F, and both `alarm` and `busy` are low.
- R2: The port is always ready, and `rsp_valid` pulses one cycle after each accepted read. Reads return data by address: 0 is the result low byte, 1 the result high byte, 2 the high trigger, 3 the low trigger and 4 the config byte. Addresses 5 to 7 read 0x00.
- R3: Config bits 6:5 hold the resolution code: 00 selects 9 bits, 01 10 bits, 10 11 bits and 11 12 bits. Bits 4:0 always read 1 and bit 7 always reads 0, whatever was written.
- R4: Writes to addresses 0, 1 and 5 to 7 change nothing that can be read back.
- R5: A `conv_start` pulse while idle captures `conv_sample` and the current code. `busy` is then high for exactly STEP_CYCLES×2^code cycles, and the result is stored as `busy` falls.
- R6: For code c, the lowest 3−c bits of the stored result are zero. The other sample bits are kept unchanged.
- R7: Result bits 15:12 are copies of sample bit 11.
- R8: A `conv_start` pulse while `busy` is high is ignored. It changes neither the latency nor the stored value.
- R9: At completion, `alarm` becomes 1 when signed result bits 11:4 are greater than the high trigger or less than the low trigger. It becomes 0 otherwise, and equality is not an alarm.
- R10: `alarm` changes only when a conversion completes, so trigger writes leave it untouched. Reads during a conversion return the previous result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_start | input | 1 | Conversion start strobe |
| conv_sample | input | 12 | Signed raw sample, 1/16 degree units |
| busy | output | 1 | Conversion in progress |
| alarm | output | 1 | Sticky threshold alarm |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Register request ready (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 3 | Register address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | 8 | Read data |

## Verification
The hardest situations to reach are the ones where the alarm flag must not move. One is when trigger bytes are rewritten after an alarming result. The other is when a second start strobe lands in the middle of a running count. The stimulus produces an alarming result and then rewrites the high trigger so that the stored value would no longer alarm. It samples the flag before any new conversion is started. A separate conversion has a foreign sample and start pulse injected part-way through its count, and the bench confirms both the unchanged latency and the original stored value.

// File: rtl/temp_scratchpad.sv
module temp_scratchpad #(
  parameter int STEP_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        conv_start,
  input  logic [11:0] conv_sample,
  output logic        busy,
  output logic        alarm,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [2:0]  req_addr,
  input  logic [7:0]  req_wdata,
  output logic        rsp_valid,
  output logic [7:0]  rsp_data
);
  localparam int CNT_W = $clog2(STEP_CYCLES * 8) + 1;
  localparam logic [CNT_W-1:0] STEP = CNT_W'(STEP_CYCLES);

  logic [15:0]      temp_q;
  logic [7:0]       hi_q, lo_q;
  logic [1:0]       res_q, cres_q;
  logic [11:0]      raw_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q, alarm_q;
  logic [7:0]       rd_mux;

  wire [7:0]  cfg_byte = {1'b0, res_q, 5'h1F};
  wire [11:0] masked   = raw_q & ~(12'h7 >> cres_q);
  wire [15:0] new_temp = {{4{masked[11]}}, masked};
  wire        over     = $signed(masked[11:4]) > $signed(hi_q);
  wire        under    = $signed(masked[11:4]) < $signed(lo_q);
  wire        rd_acc   = req_valid && !req_write;
  wire        wr_acc   = req_valid && req_write;

  assign req_ready = 1'b1;
  assign busy      = busy_q;
  assign alarm     = alarm_q;

  always_comb begin
    case (req_addr)
      3'd0:    rd_mux = temp_q[7:0];
      3'd1:    rd_mux = temp_q[15:8];
      3'd2:    rd_mux = hi_q;
      3'd3:    rd_mux = lo_q;
      3'd4:    rd_mux = cfg_byte;
      default: rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q  <= 8'h7F;
      lo_q  <= 8'h80;
      res_q <= 2'b11;
    end else if (wr_acc) begin
      case (req_addr)
        3'd2:    hi_q  <= req_wdata;
        3'd3:    lo_q  <= req_wdata;
        3'd4:    res_q <= req_wdata[6:5];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= 8'h00;
    end else begin
      rsp_valid <= rd_acc;
      if (rd_acc) rsp_data <= rd_mux;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      raw_q   <= '0;
      cres_q  <= '0;
      temp_q  <= '0;
      alarm_q <= 1'b0;
    end else if (!busy_q) begin
      if (conv_start) begin
        busy_q <= 1'b1;
        raw_q  <= conv_sample;
        cres_q <= res_q;
        cnt_q  <= (STEP << res_q) - CNT_W'(1);
      end
    end else if (cnt_q == '0) begin
      busy_q  <= 1'b0;
      temp_q  <= new_temp;
      alarm_q <= over || under;
    end else begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  // R3
  cfg_const_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_acc && req_addr == 3'd4) |-> (rsp_data[7] == 1'b0 && rsp_data[4:0] == 5'h1F));

  // R2
  rsp_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(rd_acc));

  // R5
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start && !busy_q) |=> busy_q);

  // R7
  sign_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy_q) && !busy_q) |-> (temp_q[15:12] == {4{temp_q[11]}}));

  // R10
  alarm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !($past(busy_q) && !busy_q) |-> $stable(alarm_q));
endmodule

// File: tb/temp_scratchpad_bench.sv
`timescale 1ns/1ps
module temp_scratchpad_bench;
  localparam int STEP = 4;

  logic clk = 0, rst_n = 0;
  logic conv_start = 0;
  logic [11:0] conv_sample = '0;
  logic busy, alarm, req_ready, rsp_valid;
  logic req_valid = 0, req_write = 0;
  logic [2:0] req_addr = '0;
  logic [7:0] req_wdata = '0, rsp_data;

  int total = 0, bad = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  logic [7:0] mon_e;
  string mon_t;
  logic [7:0] cur_hi = 8'h7F, cur_lo = 8'h80;

  always #2 clk = ~clk;

  temp_scratchpad #(.STEP_CYCLES(STEP)) u_temp_scratchpad (
    .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .conv_sample(conv_sample),
    .busy(busy), .alarm(alarm), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data));

  task automatic chk(input string t, input logic [15:0] act, input logic [15:0] e);
    total++;
    if (act !== e) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", t, act, e);
    end
  endtask

  always @(negedge clk) begin
    if (rsp_valid) begin
      if (exp_q.size() == 0) chk("R2 unexpected response", 16'h1, 16'h0);
      else begin
        mon_e = exp_q.pop_front();
        mon_t = tag_q.pop_front();
        chk(mon_t, {8'h0, rsp_data}, {8'h0, mon_e});
      end
    end
  end

  task automatic rd(input logic [2:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    if (a == 3'd2) cur_hi = d;
    if (a == 3'd3) cur_lo = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  function automatic logic [15:0] expt(input logic [11:0] s, input logic [1:0] c);
    logic [11:0] m = s;
    for (int i = 0; i < 3 - int'(c); i++) m[i] = 1'b0;
    return {{4{m[11]}}, m};
  endfunction

  function automatic logic exp_alarm(input logic [15:0] t);
    return ($signed(t[11:4]) > $signed(cur_hi)) || ($signed(t[11:4]) < $signed(cur_lo));
  endfunction

  task automatic conv(input logic [11:0] s, input logic [1:0] c, input bit inj, input string t);
    int n = 0;
    logic [15:0] e = expt(s, c);
    @(negedge clk);
    conv_start = 1; conv_sample = s;
    @(negedge clk);
    conv_start = 0;
    while (busy) begin
      n++;
      if (inj && n == 2) begin conv_start = 1; conv_sample = ~s; end
      else conv_start = 0;
      @(negedge clk);
    end
    conv_start = 0;
    chk({t, " R5 latency"}, 16'(n), 16'(STEP << c));
    rd(3'd0, e[7:0], {t, " R6 low byte"});
    rd(3'd1, e[15:8], {t, " R7 high byte"});
    chk({t, " R9 alarm"}, {15'h0, alarm}, {15'h0, exp_alarm(e)});
  endtask

  initial begin
    #(200000 * 4);
    chk("watchdog expired", 16'h1, 16'h0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1 busy", {15'h0, busy}, 16'h0);
    chk("R1 alarm", {15'h0, alarm}, 16'h0);
    chk("R2 ready", {15'h0, req_ready}, 16'h1);
    rd(3'd0, 8'h00, "R1 temp lo");
    rd(3'd1, 8'h00, "R1 temp hi");
    rd(3'd2, 8'h7F, "R1 high trigger");
    rd(3'd3, 8'h80, "R1 low trigger");
    rd(3'd4, 8'h7F, "R1 config");
    rd(3'd5, 8'h00, "R2 unused addr");

    wr(3'd4, 8'h00); rd(3'd4, 8'h1F, "R3 cfg 00");
    wr(3'd4, 8'hFF); rd(3'd4, 8'h7F, "R3 cfg FF");
    wr(3'd4, 8'hA0); rd(3'd4, 8'h3F, "R3 cfg A0");

    wr(3'd0, 8'hAA); wr(3'd1, 8'h55); wr(3'd6, 8'hFF);
    rd(3'd0, 8'h00, "R4 temp lo unchanged");
    rd(3'd1, 8'h00, "R4 temp hi unchanged");
    rd(3'd6, 8'h00, "R4 unused unchanged");

    wr(3'd4, 8'h60); conv(12'h191, 2'd3, 0, "res12");
    wr(3'd4, 8'h00); conv(12'hFF5, 2'd0, 0, "res9");
    wr(3'd4, 8'h20); conv(12'h7D7, 2'd1, 0, "res10");
    wr(3'd4, 8'h40); conv(12'h123, 2'd2, 0, "res11");

    wr(3'd4, 8'h60);
    wr(3'd2, 8'h19); wr(3'd3, 8'hF6);
    conv(12'h1A8, 2'd3, 0, "above high");
    chk("R9 alarm set", {15'h0, alarm}, 16'h1);
    wr(3'd2, 8'h1E);
    chk("R10 alarm held after trigger write", {15'h0, alarm}, 16'h1);
    conv(12'h190, 2'd3, 0, "inside");
    chk("R9 alarm cleared", {15'h0, alarm}, 16'h0);
    conv(12'hF50, 2'd3, 0, "below low");
    chk("R9 alarm below", {15'h0, alarm}, 16'h1);
    conv(12'h1EF, 2'd3, 0, "equal high");
    chk("R9 equal high no alarm", {15'h0, alarm}, 16'h0);
    conv(12'hF60, 2'd3, 0, "equal low");
    chk("R9 equal low no alarm", {15'h0, alarm}, 16'h0);

    conv(12'h2A5, 2'd3, 1, "R8 injected start");

    @(negedge clk);
    conv_start = 1; conv_sample = 12'h0C3;
    @(negedge clk);
    conv_start = 0;
    rd(3'd0, 8'hA5, "R10 read during busy lo");
    rd(3'd1, 8'h02, "R10 read during busy hi");
    while (busy) @(negedge clk);
    rd(3'd0, 8'hC3, "R5 after busy lo");
    rd(3'd1, 8'h00, "R5 after busy hi");

    repeat (4) @(negedge clk);
    chk("R2 all responses seen", 16'(exp_q.size()), 16'h0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule